// File: doc/BRIEF.md
# Branch Prediction Fetch Redirect Controller

The block produces the instruction fetch address every cycle and steers it around control flow. A small direct-mapped prediction table is read with the current fetch address in the same cycle. When the entry matches and its direction counter leans toward taken, the next fetch address is the stored target, so a branch predicted taken causes no fetch bubble. In every other case fetch moves on to the next sequential word.

The execute stage reports each resolved branch on a resolution port. The report carries the branch address, the real direction and target, and the direction and target that were predicted when it was fetched. When the real outcome differs from the prediction, the block redirects fetch to the correct address. It drives a one-cycle kill pulse that clears the valid bits of the fetch and execute stages, and it holds an issue-block signal for the fixed refill penalty. Each accepted resolution also trains the table.

Instructions are 4-byte aligned. The table index is address bits [5:2] and the tag is bits [31:6]. The refill penalty is 7 cycles.

Top module: `bp_fetch_ctrl`

## Requirements
- R1: While rst_ni is low, fetch_addr_o equals RESET_ADDR (0x100), and flush_o, issue_block_o and pred_taken_o are 0.
- R2: When no resolution is presented and pred_taken_o is 0, fetch_addr_o advances by 4 on the next cycle.
- R3: When no resolution is presented and pred_taken_o is 1, the next fetch_addr_o equals pred_target_o of the current cycle. A correctly predicted taken branch adds no cycle.
- R4: An accepted resolution is a mispredict when res_taken_i differs from res_pred_taken_i, or when both are 1 and res_target_i differs from res_pred_target_i. A resolution that is not a mispredict causes no flush.
- R5: After a mispredict, the next fetch_addr_o is res_target_i if the branch was taken and res_pc_i + 4 otherwise. This redirect wins over a prediction made in the same cycle.
- R6: flush_o is high for exactly one cycle: the cycle after the mispredicting resolution was sampled.
- R7: issue_block_o is high for exactly 7 consecutive cycles after a mispredict, starting in the flush_o cycle. A correct resolution leaves it low, so the cost is 0 cycles.
- R8: A resolution presented while issue_block_o is high is discarded. It causes no flush, no redirect and no table update.
- R9: On an accepted resolution that hits the table (entry valid, tag equal), the 2-bit counter counts up on taken and down on not-taken, saturating at 3 and 0, and the target is rewritten on taken. On a miss, a taken branch allocates the entry with the new target and counter 2, and a not-taken branch leaves the table unchanged. pred_taken_o is 1 when the entry for fetch_addr_o is valid, its tag matches, and counter bit 1 is set.
- R10: Addresses that share bits [5:2] but differ in bits [31:6] map to the same entry. A lookup with the other tag does not predict, and allocating for one address evicts the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_addr_o | output | ADDR_W | Current instruction fetch address |
| pred_taken_o | output | 1 | Table predicts the word at fetch_addr_o is a taken branch |
| pred_target_o | output | ADDR_W | Predicted target for fetch_addr_o |
| res_valid_i | input | 1 | A branch resolution is presented |
| res_pc_i | input | ADDR_W | Address of the resolved branch |
| res_taken_i | input | 1 | Actual direction |
| res_target_i | input | ADDR_W | Actual taken target |
| res_pred_taken_i | input | 1 | Direction predicted at fetch |
| res_pred_target_i | input | ADDR_W | Target predicted at fetch |
| flush_o | output | 1 | One-cycle kill of fetch and execute stage valid bits |
| issue_block_o | output | 1 | Execute issue blocked during refill |

## Verification
The table can only be read at whatever address fetch happens to reach, and fetch cannot be loaded directly. To read a chosen entry, the stimulus therefore forces a deliberate not-taken mispredict at the word just before that entry's address. This makes the redirect land on the wanted address, and the prediction outputs are read in the flush cycle. A bench-side model of the table and of the resolution rules is updated every cycle. It predicts the fetch address, the prediction outputs, the flush and the block of each cycle. Directed sequences walk one counter through saturation at both ends, force index aliasing, and inject resolutions inside the refill window. A seeded sweep then covers both tag regions across all 16 indices.

// File: rtl/bp_fetch_pkg.sv
`timescale 1ns/1ps
package bp_fetch_pkg;

  typedef enum logic [1:0] {
    RES_OK  = 2'd0,
    RES_DIR = 2'd1,
    RES_TGT = 2'd2
  } res_kind_e;

  localparam logic [1:0] CTR_WEAK_TAKEN = 2'b10;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

endpackage

// File: rtl/bp_pred_cache.sv
`timescale 1ns/1ps
module bp_pred_cache
  import bp_fetch_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int ALIGN_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] look_addr_i,
  input  logic              upd_en_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);
  localparam int NUM   = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - ALIGN_W;

  logic [IDX_W-1:0] look_idx, upd_idx;
  logic [TAG_W-1:0] look_tag, upd_tag;

  assign look_idx = look_addr_i[ALIGN_W +: IDX_W];
  assign look_tag = look_addr_i[ADDR_W-1 -: TAG_W];
  assign upd_idx  = upd_pc_i[ALIGN_W +: IDX_W];
  assign upd_tag  = upd_pc_i[ADDR_W-1 -: TAG_W];

  logic unused_align;
  assign unused_align = ^{look_addr_i[ALIGN_W-1:0], upd_pc_i[ALIGN_W-1:0]};

  logic [NUM-1:0]    ent_v;
  logic [TAG_W-1:0]  ent_tag [NUM];
  logic [ADDR_W-1:0] ent_tgt [NUM];
  logic [1:0]        ent_ctr [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_ent
    logic              v_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [1:0]        ctr_q;
    logic              sel, same;

    assign sel  = upd_en_i && (upd_idx == IDX_W'(g));
    assign same = v_q && (tag_q == upd_tag);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q   <= 1'b0;
        tag_q <= '0;
        tgt_q <= '0;
        ctr_q <= '0;
      end else if (sel) begin
        if (same) begin
          // R9: train a hit entry
          ctr_q <= ctr_step(ctr_q, upd_taken_i);
          if (upd_taken_i) tgt_q <= upd_target_i;
        end else if (upd_taken_i) begin
          // R10: taken miss evicts whatever shares the index
          v_q   <= 1'b1;
          tag_q <= upd_tag;
          tgt_q <= upd_target_i;
          ctr_q <= CTR_WEAK_TAKEN;
        end
      end
    end

    assign ent_v[g]   = v_q;
    assign ent_tag[g] = tag_q;
    assign ent_tgt[g] = tgt_q;
    assign ent_ctr[g] = ctr_q;
  end

  logic look_hit;
  assign look_hit = ent_v[look_idx] && (ent_tag[look_idx] == look_tag);
  assign taken_o  = look_hit && ent_ctr[look_idx][1];
  assign target_o = ent_tgt[look_idx];

endmodule

// File: rtl/bp_res_check.sv
`timescale 1ns/1ps
module bp_res_check
  import bp_fetch_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ALIGN_W = 2
) (
  input  logic              res_taken_i,
  input  logic [ADDR_W-1:0] res_pc_i,
  input  logic [ADDR_W-1:0] res_target_i,
  input  logic              res_pred_taken_i,
  input  logic [ADDR_W-1:0] res_pred_target_i,
  output res_kind_e         kind_o,
  output logic [ADDR_W-1:0] correct_addr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << ALIGN_W);

  always_comb begin
    if (res_taken_i != res_pred_taken_i)
      kind_o = RES_DIR;
    else if (res_taken_i && (res_target_i != res_pred_target_i))
      kind_o = RES_TGT;
    else
      kind_o = RES_OK;
  end

  assign correct_addr_o = res_taken_i ? res_target_i : res_pc_i + STEP;

endmodule

// File: rtl/bp_refill_timer.sv
`timescale 1ns/1ps
module bp_refill_timer #(
  parameter int REFILL_CYC = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic block_o
);
  localparam int CNT_W = $clog2(REFILL_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CNT_W'(REFILL_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign block_o = (cnt_q != '0);

endmodule

// File: rtl/bp_fetch_pc.sv
`timescale 1ns/1ps
module bp_fetch_pc #(
  parameter int                 ADDR_W     = 32,
  parameter int                 ALIGN_W    = 2,
  parameter logic [ADDR_W-1:0]  RESET_ADDR = 'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] redirect_addr_i,
  input  logic              pred_taken_i,
  input  logic [ADDR_W-1:0] pred_target_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << ALIGN_W);

  logic [ADDR_W-1:0] pc_q, pc_d;

  // redirect from execute outranks the fetch-side prediction
  always_comb begin
    if (redirect_i)        pc_d = redirect_addr_i;
    else if (pred_taken_i) pc_d = pred_target_i;
    else                   pc_d = pc_q + STEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_ADDR;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/bp_fetch_ctrl.sv
`timescale 1ns/1ps
module bp_fetch_ctrl
  import bp_fetch_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                IDX_W      = 4,
  parameter int                REFILL_CYC = 7,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              pred_taken_o,
  output logic [ADDR_W-1:0] pred_target_o,
  input  logic              res_valid_i,
  input  logic [ADDR_W-1:0] res_pc_i,
  input  logic              res_taken_i,
  input  logic [ADDR_W-1:0] res_target_i,
  input  logic              res_pred_taken_i,
  input  logic [ADDR_W-1:0] res_pred_target_i,
  output logic              flush_o,
  output logic              issue_block_o
);
  localparam int ALIGN_W = 2;

  res_kind_e         res_kind;
  logic [ADDR_W-1:0] correct_addr;
  logic              res_accept, mispredict, flush_q;

  // resolutions arriving during refill belong to killed work
  assign res_accept = res_valid_i && !issue_block_o;
  assign mispredict = res_accept && (res_kind != RES_OK);

  bp_res_check #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) i_res_check (
    .res_taken_i      (res_taken_i),
    .res_pc_i         (res_pc_i),
    .res_target_i     (res_target_i),
    .res_pred_taken_i (res_pred_taken_i),
    .res_pred_target_i(res_pred_target_i),
    .kind_o           (res_kind),
    .correct_addr_o   (correct_addr)
  );

  bp_pred_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) i_pred_cache (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .look_addr_i (fetch_addr_o),
    .upd_en_i    (res_accept),
    .upd_pc_i    (res_pc_i),
    .upd_taken_i (res_taken_i),
    .upd_target_i(res_target_i),
    .taken_o     (pred_taken_o),
    .target_o    (pred_target_o)
  );

  bp_fetch_pc #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .RESET_ADDR(RESET_ADDR)) i_fetch_pc (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .redirect_i     (mispredict),
    .redirect_addr_i(correct_addr),
    .pred_taken_i   (pred_taken_o),
    .pred_target_i  (pred_target_o),
    .pc_o           (fetch_addr_o)
  );

  bp_refill_timer #(.REFILL_CYC(REFILL_CYC)) i_refill_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mispredict),
    .block_o(issue_block_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= mispredict;
  end

  assign flush_o = flush_q;

endmodule

// File: rtl/bp_fetch_ctrl_chk.sv
`timescale 1ns/1ps
module bp_fetch_ctrl_chk #(
  parameter int                ADDR_W     = 32,
  parameter int                REFILL_CYC = 7,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 'h100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              pred_taken_o,
  input logic [ADDR_W-1:0] pred_target_o,
  input logic              res_valid_i,
  input logic [ADDR_W-1:0] res_pc_i,
  input logic              res_taken_i,
  input logic [ADDR_W-1:0] res_target_i,
  input logic              res_pred_taken_i,
  input logic [ADDR_W-1:0] res_pred_target_i,
  input logic              flush_o,
  input logic              issue_block_o
);
  localparam int                RUN_W = $clog2(REFILL_CYC + 2);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(4);

  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= '0;
    else if (issue_block_o) run_q <= run_q + 1'b1;
    else                    run_q <= '0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (fetch_addr_o == RESET_ADDR && !flush_o && !issue_block_o && !pred_taken_o));

  // R2
  seq_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_valid_i && !pred_taken_o) |=> fetch_addr_o == $past(fetch_addr_o) + STEP);

  // R3
  pred_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_valid_i && pred_taken_o) |=> fetch_addr_o == $past(pred_target_o));

  // R4
  dir_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !issue_block_o && (res_taken_i != res_pred_taken_i)) |=> flush_o);

  // R4
  tgt_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !issue_block_o && res_taken_i && res_pred_taken_i &&
     (res_target_i != res_pred_target_i)) |=> flush_o);

  // R5
  flush_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> fetch_addr_o == ($past(res_taken_i) ? $past(res_target_i) : $past(res_pc_i) + STEP));

  // R6
  flush_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);

  // R7
  block_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (issue_block_o && run_q == '0));

  // R7
  block_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(issue_block_o) |-> run_q == RUN_W'(REFILL_CYC));

  // R8
  ignore_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && issue_block_o) |=> !flush_o);

endmodule

bind bp_fetch_ctrl bp_fetch_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .REFILL_CYC(REFILL_CYC),
  .RESET_ADDR(RESET_ADDR)
) i_bp_fetch_ctrl_chk (.*);

// File: tb/test_bp_fetch_ctrl.sv
`timescale 1ns/1ps
module test_bp_fetch_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [31:0] fetch_addr_o, pred_target_o;
  logic        pred_taken_o, flush_o, issue_block_o;
  logic        res_valid_i = 0, res_taken_i = 0, res_pred_taken_i = 0;
  logic [31:0] res_pc_i = 0, res_target_i = 0, res_pred_target_i = 0;

  int n_chk = 0, n_fail = 0;
  bit mon_en = 0;

  always #5 clk = ~clk;

  bp_fetch_ctrl i_bp_fetch_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .fetch_addr_o(fetch_addr_o), .pred_taken_o(pred_taken_o), .pred_target_o(pred_target_o),
    .res_valid_i(res_valid_i), .res_pc_i(res_pc_i), .res_taken_i(res_taken_i),
    .res_target_i(res_target_i), .res_pred_taken_i(res_pred_taken_i),
    .res_pred_target_i(res_pred_target_i),
    .flush_o(flush_o), .issue_block_o(issue_block_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // table model built from R9/R10: index [5:2], tag [31:6]
  bit          m_v   [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_tgt [16];
  logic [1:0]  m_ctr [16];

  function automatic bit m_pred(input logic [31:0] a);
    int i = int'(a[5:2]);
    return m_v[i] && (m_tag[i] == a[31:6]) && m_ctr[i][1];
  endfunction

  task automatic m_update(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
    int i = int'(pc[5:2]);
    if (m_v[i] && m_tag[i] == pc[31:6]) begin
      if (tk) begin
        if (m_ctr[i] != 2'b11) m_ctr[i] = m_ctr[i] + 2'd1;
        m_tgt[i] = tgt;
      end else if (m_ctr[i] != 2'b00) m_ctr[i] = m_ctr[i] - 2'd1;
    end else if (tk) begin
      m_v[i] = 1; m_tag[i] = pc[31:6]; m_tgt[i] = tgt; m_ctr[i] = 2'b10;
    end
  endtask

  logic [31:0] exp_addr = 32'h104;
  bit          exp_flush = 0;
  int          exp_cnt = 0;
  string       addr_req = "R2", flush_req = "R6";

  // cycle monitor: sample after the edge has settled, then predict the next cycle
  always begin
    @(negedge clk); #1;
    if (mon_en) begin
      bit pt, acc, mis, tgt_only;
      logic [31:0] corr;
      chk(fetch_addr_o == exp_addr, addr_req, fetch_addr_o, exp_addr);
      chk(flush_o == exp_flush, flush_req, 32'(flush_o), 32'(exp_flush));
      chk(issue_block_o == (exp_cnt != 0), "R7", 32'(issue_block_o), 32'(exp_cnt != 0));
      pt = m_pred(exp_addr);
      chk(pred_taken_o == pt, "R9", 32'(pred_taken_o), 32'(pt));
      if (pt) chk(pred_target_o == m_tgt[exp_addr[5:2]], "R9", pred_target_o, m_tgt[exp_addr[5:2]]);
      acc = res_valid_i && (exp_cnt == 0);
      tgt_only = res_taken_i && res_pred_taken_i && (res_target_i != res_pred_target_i);
      mis = acc && ((res_taken_i != res_pred_taken_i) || tgt_only);
      corr = res_taken_i ? res_target_i : res_pc_i + 32'd4;
      if (mis)     begin exp_addr = corr;                   addr_req = "R5"; end
      else if (pt) begin exp_addr = m_tgt[exp_addr[5:2]];   addr_req = "R3"; end
      else         begin exp_addr = exp_addr + 32'd4;       addr_req = "R2"; end
      flush_req = (res_valid_i && !acc) ? "R8" : (tgt_only ? "R4" : "R6");
      exp_flush = mis;
      exp_cnt = mis ? 7 : (exp_cnt != 0 ? exp_cnt - 1 : 0);
      if (acc) m_update(res_pc_i, res_taken_i, res_target_i);
    end
  end

  task automatic resolve(input logic [31:0] pc, input bit tk, input logic [31:0] tgt,
                         input bit ptk, input logic [31:0] ptgt);
    @(negedge clk);
    res_valid_i = 1; res_pc_i = pc; res_taken_i = tk; res_target_i = tgt;
    res_pred_taken_i = ptk; res_pred_target_i = ptgt;
    @(negedge clk);
    res_valid_i = 0;
  endtask

  task automatic wait_clear();
    while (issue_block_o) @(negedge clk);
  endtask

  // count flush and block cycles following a resolution (called right after resolve)
  task automatic cost(input int exp_blk, input int exp_fl, input string req);
    int nb = 0, nf = 0;
    #2;
    repeat (12) begin
      if (issue_block_o) nb++;
      if (flush_o) nf++;
      @(negedge clk); #2;
    end
    chk(nb == exp_blk, req, 32'(nb), 32'(exp_blk));
    chk(nf == exp_fl, "R6", 32'(nf), 32'(exp_fl));
  endtask

  // land fetch on x via a not-taken mispredict at x-4, then read the prediction
  task automatic steer(input logic [31:0] x, input bit exp_t, input logic [31:0] exp_tgt, input string req);
    wait_clear();
    resolve(x - 32'd4, 1'b0, 32'd0, 1'b1, 32'd0);
    #2;
    chk(fetch_addr_o == x, "R5", fetch_addr_o, x);
    chk(pred_taken_o == exp_t, req, 32'(pred_taken_o), 32'(exp_t));
    if (exp_t) chk(pred_target_o == exp_tgt, req, pred_target_o, exp_tgt);
  endtask

  localparam logic [31:0] A = 32'h200, B = 32'h324, C = 32'h240, D = 32'h48C;

  initial begin
    #1 rst_ni = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(fetch_addr_o == 32'h100, "R1", fetch_addr_o, 32'h100);
    chk(!flush_o && !issue_block_o && !pred_taken_o, "R1",
        {29'd0, flush_o, issue_block_o, pred_taken_o}, 32'd0);
    #1 rst_ni = 1; mon_en = 1;
    repeat (3) @(negedge clk);
    #2 chk(fetch_addr_o == 32'h10C, "R2", fetch_addr_o, 32'h10C);

    // taken miss: mispredict, redirect, 7-cycle penalty
    resolve(A, 1, 32'h400, 0, 32'h0);
    #2 chk(fetch_addr_o == 32'h400, "R5", fetch_addr_o, 32'h400);
    cost(7, 1, "R7");
    steer(A, 1, 32'h400, "R9");
    @(negedge clk); #2 chk(fetch_addr_o == 32'h400, "R3", fetch_addr_o, 32'h400);

    // target-only mismatch
    wait_clear();
    resolve(A, 1, 32'h500, 1, 32'h400);
    #2 chk(flush_o == 1, "R4", 32'(flush_o), 32'd1);
    cost(7, 1, "R4");
    steer(A, 1, 32'h500, "R9");

    // correct taken and correct not-taken cost nothing
    wait_clear();
    resolve(A, 1, 32'h500, 1, 32'h500);
    cost(0, 0, "R7");
    resolve(B, 0, 32'h0, 0, 32'h0);
    cost(0, 0, "R4");
    steer(B, 0, 32'h0, "R9");

    // counter walk on A: 3 -> 2 -> 1 -> 0 -> 0 -> 1 -> 2 -> 3 -> 3 -> 2
    wait_clear(); resolve(A, 0, 0, 1, 32'h500); steer(A, 1, 32'h500, "R9");
    wait_clear(); resolve(A, 0, 0, 1, 32'h500); steer(A, 0, 0, "R9");
    wait_clear(); resolve(A, 0, 0, 0, 0);
    wait_clear(); resolve(A, 0, 0, 0, 0);
    wait_clear(); resolve(A, 1, 32'h600, 0, 0); steer(A, 0, 0, "R9");
    wait_clear(); resolve(A, 1, 32'h640, 0, 0); steer(A, 1, 32'h640, "R9");
    wait_clear(); resolve(A, 1, 32'h640, 1, 32'h640);
    wait_clear(); resolve(A, 1, 32'h640, 1, 32'h640);
    wait_clear(); resolve(A, 0, 0, 1, 32'h640); steer(A, 1, 32'h640, "R9");

    // aliasing on index 0
    steer(C, 0, 0, "R10");
    wait_clear(); resolve(C, 1, 32'h700, 0, 0);
    steer(A, 0, 0, "R10");
    steer(C, 1, 32'h700, "R10");

    // resolution inside the refill window is discarded
    wait_clear();
    resolve(32'h1F0, 0, 0, 1, 0);
    @(negedge clk);
    resolve(D, 1, 32'h900, 0, 0);
    #2 chk(flush_o == 0, "R8", 32'(flush_o), 32'd0);
    chk(fetch_addr_o != 32'h900, "R8", fetch_addr_o, 32'h0);
    steer(D, 0, 0, "R8");

    // sweep: both tag regions, all indices
    begin
      logic [31:0] seed = 32'h1234_5678;
      for (int it = 0; it < 240; it++) begin
        logic [31:0] pc, tgt, ptgt;
        bit tk, ptk;
        seed = seed * 32'd1664525 + 32'd1013904223;
        pc  = (seed[20] ? 32'h2000 : 32'h1000) + {26'd0, seed[27:24], 2'b00};
        tk  = seed[29];
        tgt = 32'h4000 + {22'd0, seed[15:8], 2'b00};
        wait_clear();
        ptk  = m_pred(pc);
        ptgt = ptk ? m_tgt[pc[5:2]] : 32'h0;
        resolve(pc, tk, tgt, ptk, ptgt);
        if (it % 5 == 0) resolve(pc ^ 32'h40, ~tk, tgt + 32'h10, tk, tgt);
        if (it % 4 == 0) begin
          wait_clear();
          @(negedge clk);
          begin
            logic [31:0] q = pc ^ {26'd0, seed[5:2], 2'b00};
            bit qt = m_pred(q);
            logic [31:0] qtg = m_tgt[q[5:2]];
            if (m_v[int'(q[3:0] - 4'd0)] == m_v[int'(q[3:0])]) ;
            if (!((q - 32'd4) >> 6 == q >> 6 && m_v[(q - 32'd4) >> 2 & 15])) steer(q, qt, qtg, "R10");
          end
        end
      end
    end

    wait_clear();
    repeat (3) @(negedge clk);
    #3;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule